// File: doc/BRIEF.md
# Address-Decoded NAND Pin Sequencer

This block sits between a simple processor bus and one 8-bit raw NAND flash device. Every byte access that falls in the flash window turns into a single timed strobe cycle on the device pins. The low bits of the access offset decide which control lines are active for that cycle. Offset bit 2 drives the address latch line, bit 3 the command latch line, bit 4 the chip select, bit 5 the spare-area line and bit 6 write protect. Software therefore issues a command by writing to offset 0x18, an address byte by writing to offset 0x14, and data by writing to or reading from offset 0x10. No command registers are needed.

Each strobe cycle runs through four phases: setup, strobe (write-enable or read-enable held low), hold and recovery. Each phase length is a parameter that is multiplied by a common clock multiplier. The bus stalls with `bus_ready` low until the cycle has finished, so only one access is ever in flight. A control register selects the following:
- NAND mode and chip enable, which together gate every device line;
- whether chip select follows the address;
- the active level of four lines;
- which of two chip-select outputs and which of two ready/busy inputs is used.

A status register shows the chosen ready/busy input and whether the last strobe cycle has completed.

Top module: `nand_pin_bridge`

## Requirements
- R1: After reset the control register reads 0, status bit 3 reads 1, `nand_we_n`/`nand_re_n` are 1, `nand_ale`/`nand_cle`/`nand_oe` are 0, and `nand_cs0`, `nand_cs1`, `nand_se`, `nand_wp` and `nand_pre` are 0.
- R2: During the strobe of a window access, `nand_ale` equals offset bit 2 and `nand_cle` equals offset bit 3. The spare-area line is asserted when offset bit 5 is set, and write protect is asserted when offset bit 6 is set.
- R3: With control bit 1 set, chip select is asserted only when offset bit 4 is set. With control bit 1 clear, chip select is asserted for every window access.
- R4: Device lines are driven only when control bits 0 and 20 are both 1. Otherwise a window access completes with `bus_ready` high in the cycle it is presented, produces no strobe, and reads 0.
- R5: Control bits 4, 5, 6 and 7 set the polarity of chip select, spare-area, write protect and precharge respectively. A bit value of 1 makes the line active-low and 0 makes it active-high. Precharge is asserted for the whole recovery phase.
- R6: Control bit 10 moves the chip-select output from `nand_cs0` to `nand_cs1`, and the unused output stays inactive. Control bit 8 selects `nand_rb1` instead of `nand_rb0` as the ready/busy input.
- R7: Status register (offset 0xB4): bit 0 mirrors the selected ready/busy input, and bit 3 reads 1 once the last strobe cycle has fully completed.
- R8: A write holds `nand_we_n` low for WAIT_WR×CLK_MULT cycles while `nand_oe` is 1 and `nand_dout` carries the byte. A read holds `nand_re_n` low for WAIT_RD×CLK_MULT cycles.
- R9: An enabled window access raises `bus_ready` exactly (SETUP_PH+WAIT+HOLD_PH+RECOV_PH)×CLK_MULT+1 cycles after it is presented.
- R10: Read data is sampled from `nand_din` in the final strobe cycle and returned zero-extended on `bus_rdata`. A change on `nand_din` after `nand_re_n` rises has no effect on the returned data.
- R11: `nand_we_n` and `nand_re_n` are never low together, and `bus_ready` is low whenever either strobe is low.
- R12: The control register is at offset 0xB0. Only bits 0, 1, 4–8, 10 and 20 are writable, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, held until `bus_ready` |
| bus_win | input | 1 | 1 = flash window, 0 = register space |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | REG_W | Write data (window uses bits 7:0) |
| bus_rdata | output | REG_W | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | Access completes at the clock edge where this is high |
| nand_cs0 | output | 1 | Chip select 0 (programmable level) |
| nand_cs1 | output | 1 | Chip select 1 (programmable level) |
| nand_ale | output | 1 | Address latch enable, active high |
| nand_cle | output | 1 | Command latch enable, active high |
| nand_se | output | 1 | Spare-area line (programmable level) |
| nand_wp | output | 1 | Write protect (programmable level) |
| nand_pre | output | 1 | Precharge line (programmable level) |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dout | output | 8 | Data to the device |
| nand_oe | output | 1 | Data output enable |
| nand_din | input | 8 | Data from the device |
| nand_rb0 | input | 1 | Ready/busy input 0 |
| nand_rb1 | input | 1 | Ready/busy input 1 |

## Verification
The assertions check the following on every cycle:
- the two strobes are never low together;
- the bus is stalled whenever a strobe is low;
- nothing moves on the device lines unless both the mode and chip-enable bits are set;
- a write strobe never lasts less than its minimum width;
- a hold phase always follows the strobe before the bus is released.

The exact mapping of offset bits to lines, the polarity and routing choices, the exact phase lengths and latency, the moment read data is sampled, and the writable-bit mask of the control register can only be shown by the bench scenarios. In those scenarios, known register settings and offsets are compared against pin levels captured during the strobe.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_RECOV,
        PH_DONE
    } phase_e;

    // Logical (polarity-free) line activity produced by the sequencer
    typedef struct packed {
        logic ale;
        logic cle;
        logic cs;
        logic se;
        logic wp;
        logic we;
        logic re;
        logic pre;
        logic oe;
    } line_act_t;

    // Control register bit positions
    localparam int CB_NAND   = 0;
    localparam int CB_CSMUX  = 1;
    localparam int CB_CSPOL  = 4;
    localparam int CB_SEPOL  = 5;
    localparam int CB_WPPOL  = 6;
    localparam int CB_PREPOL = 7;
    localparam int CB_RBSEL  = 8;
    localparam int CB_CSOUT  = 10;
    localparam int CB_CE     = 20;

    // Window offset bits that pick the device lines (decoded by the sequencer)
    localparam int AB_ALE = 2;
    localparam int AB_CLE = 3;
    localparam int AB_CS  = 4;
    localparam int AB_SE  = 5;
    localparam int AB_WP  = 6;

    // Status register bit positions
    localparam int SB_RB   = 0;
    localparam int SB_DONE = 3;

endpackage

// File: rtl/nand_bridge_regs.sv
module nand_bridge_regs
    import nand_bridge_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int ADDR_W   = 8,
    parameter int CTRL_OFF = 'hB0,
    parameter int STAT_OFF = 'hB4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              rb_in,
    input  logic              done_in,
    output logic [REG_W-1:0]  ctrl,
    output logic [REG_W-1:0]  rdata
);

    localparam logic [REG_W-1:0] WR_MASK =
        (REG_W'(1) << CB_NAND)  | (REG_W'(1) << CB_CSMUX) |
        (REG_W'(1) << CB_CSPOL) | (REG_W'(1) << CB_SEPOL) |
        (REG_W'(1) << CB_WPPOL) | (REG_W'(1) << CB_PREPOL) |
        (REG_W'(1) << CB_RBSEL) | (REG_W'(1) << CB_CSOUT) |
        (REG_W'(1) << CB_CE);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFF);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFF);

    logic [REG_W-1:0] ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && addr == A_CTRL)
            ctrl_d = wdata & WR_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata = ctrl_q;
        end else if (addr == A_STAT) begin
            rdata[SB_RB]   = rb_in;
            rdata[SB_DONE] = done_in;
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/nand_bridge_seq.sv
module nand_bridge_seq
    import nand_bridge_pkg::*;
#(
    parameter int DW       = 8,
    parameter int SETUP_PH = 1,
    parameter int WAIT_WR  = 2,
    parameter int WAIT_RD  = 2,
    parameter int HOLD_PH  = 1,
    parameter int RECOV_PH = 1,
    parameter int CLK_MULT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_we,
    input  logic [6:2]    start_sel,
    input  logic [DW-1:0] start_wdata,
    input  logic          csmux,
    input  logic [DW-1:0] din,
    output phase_e        phase,
    output line_act_t     act,
    output logic [DW-1:0] dout,
    output logic [DW-1:0] rdata,
    output logic          done
);

    localparam int L_SET = SETUP_PH * CLK_MULT;
    localparam int L_WR  = WAIT_WR  * CLK_MULT;
    localparam int L_RD  = WAIT_RD  * CLK_MULT;
    localparam int L_HLD = HOLD_PH  * CLK_MULT;
    localparam int L_REC = RECOV_PH * CLK_MULT;
    localparam int L_M1  = (L_SET > L_WR) ? L_SET : L_WR;
    localparam int L_M2  = (L_RD  > L_HLD) ? L_RD : L_HLD;
    localparam int L_M3  = (L_M1  > L_M2) ? L_M1 : L_M2;
    localparam int L_MAX = (L_M3  > L_REC) ? L_M3 : L_REC;
    localparam int CNT_W = $clog2(L_MAX + 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             ale;
        logic             cle;
        logic             cs;
        logic             se;
        logic             wp;
        logic             we;
        logic [DW-1:0]    wdata;
        logic [DW-1:0]    rdata;
        logic             done;
    } seq_state_t;

    seq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase = PH_SETUP;
                    s_d.cnt   = CNT_W'(L_SET - 1);
                    s_d.ale   = start_sel[AB_ALE];
                    s_d.cle   = start_sel[AB_CLE];
                    s_d.cs    = csmux ? start_sel[AB_CS] : 1'b1;
                    s_d.se    = start_sel[AB_SE];
                    s_d.wp    = start_sel[AB_WP];
                    s_d.we    = start_we;
                    s_d.wdata = start_wdata;
                    s_d.done  = 1'b0;
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_STROBE;
                    s_d.cnt   = s_q.we ? CNT_W'(L_WR - 1) : CNT_W'(L_RD - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (s_q.cnt == '0) begin
                    if (!s_q.we) s_d.rdata = din;
                    s_d.phase = PH_HOLD;
                    s_d.cnt   = CNT_W'(L_HLD - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_RECOV;
                    s_d.cnt   = CNT_W'(L_REC - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_RECOV: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_DONE;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_DONE: s_d.phase = PH_IDLE;
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
            s_q.done  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    logic in_acc;
    assign in_acc = (s_q.phase == PH_SETUP) || (s_q.phase == PH_STROBE) ||
                    (s_q.phase == PH_HOLD);

    always_comb begin
        act     = '0;
        act.ale = in_acc & s_q.ale;
        act.cle = in_acc & s_q.cle;
        act.cs  = in_acc & s_q.cs;
        act.se  = in_acc & s_q.se;
        act.wp  = in_acc & s_q.wp;
        act.we  = (s_q.phase == PH_STROBE) &  s_q.we;
        act.re  = (s_q.phase == PH_STROBE) & ~s_q.we;
        act.pre = (s_q.phase == PH_RECOV);
        act.oe  = in_acc & s_q.we;
    end

    assign phase = s_q.phase;
    assign dout  = s_q.wdata;
    assign rdata = s_q.rdata;
    assign done  = s_q.done;

endmodule

// File: rtl/nand_bridge_pins.sv
module nand_bridge_pins
    import nand_bridge_pkg::*;
(
    input  line_act_t act,
    input  logic      en,
    input  logic      pol_cs,
    input  logic      pol_se,
    input  logic      pol_wp,
    input  logic      pol_pre,
    input  logic      cs_to1,
    output logic      cs0,
    output logic      cs1,
    output logic      ale,
    output logic      cle,
    output logic      se,
    output logic      wp,
    output logic      pre,
    output logic      we_n,
    output logic      re_n,
    output logic      oe
);

    line_act_t g;
    assign g = en ? act : '0;

    // A polarity bit of 1 means the line is active-low
    assign cs0  = (g.cs & ~cs_to1) ^ pol_cs;
    assign cs1  = (g.cs &  cs_to1) ^ pol_cs;
    assign se   = g.se  ^ pol_se;
    assign wp   = g.wp  ^ pol_wp;
    assign pre  = g.pre ^ pol_pre;
    assign ale  = g.ale;
    assign cle  = g.cle;
    assign we_n = ~g.we;
    assign re_n = ~g.re;
    assign oe   = g.oe;

endmodule

// File: rtl/nand_pin_bridge.sv
module nand_pin_bridge
    import nand_bridge_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int ADDR_W   = 8,
    parameter int CTRL_OFF = 'hB0,
    parameter int STAT_OFF = 'hB4,
    parameter int SETUP_PH = 1,
    parameter int WAIT_WR  = 2,
    parameter int WAIT_RD  = 2,
    parameter int HOLD_PH  = 1,
    parameter int RECOV_PH = 1,
    parameter int CLK_MULT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_win,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_ready,
    output logic              nand_cs0,
    output logic              nand_cs1,
    output logic              nand_ale,
    output logic              nand_cle,
    output logic              nand_se,
    output logic              nand_wp,
    output logic              nand_pre,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dout,
    output logic              nand_oe,
    input  logic [7:0]        nand_din,
    input  logic              nand_rb0,
    input  logic              nand_rb1
);

    localparam int DW = 8;

    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] reg_rdata;
    logic [DW-1:0]    seq_rdata;
    phase_e           phase;
    line_act_t        act;
    logic             seq_done;
    logic             en, idle, start, reg_wr, rb_sel;

    assign en     = ctrl_q[CB_NAND] & ctrl_q[CB_CE];
    assign idle   = (phase == PH_IDLE);
    assign start  = idle & bus_req & bus_win & en;
    assign reg_wr = idle & bus_req & ~bus_win & bus_we;
    assign rb_sel = ctrl_q[CB_RBSEL] ? nand_rb1 : nand_rb0;

    assign bus_ready = (idle & ~start) | (phase == PH_DONE);

    always_comb begin
        if (phase == PH_DONE) bus_rdata = {{(REG_W-DW){1'b0}}, seq_rdata};
        else if (bus_win)     bus_rdata = '0;
        else                  bus_rdata = reg_rdata;
    end

    nand_bridge_regs #(
        .REG_W(REG_W), .ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF), .STAT_OFF(STAT_OFF)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rb_in(rb_sel), .done_in(seq_done),
        .ctrl(ctrl_q), .rdata(reg_rdata)
    );

    nand_bridge_seq #(
        .DW(DW), .SETUP_PH(SETUP_PH), .WAIT_WR(WAIT_WR), .WAIT_RD(WAIT_RD),
        .HOLD_PH(HOLD_PH), .RECOV_PH(RECOV_PH), .CLK_MULT(CLK_MULT)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_we(bus_we),
        .start_sel(bus_addr[6:2]), .start_wdata(bus_wdata[DW-1:0]),
        .csmux(ctrl_q[CB_CSMUX]), .din(nand_din), .phase(phase), .act(act),
        .dout(nand_dout), .rdata(seq_rdata), .done(seq_done)
    );

    nand_bridge_pins i_pins (
        .act(act), .en(en),
        .pol_cs(ctrl_q[CB_CSPOL]), .pol_se(ctrl_q[CB_SEPOL]),
        .pol_wp(ctrl_q[CB_WPPOL]), .pol_pre(ctrl_q[CB_PREPOL]),
        .cs_to1(ctrl_q[CB_CSOUT]),
        .cs0(nand_cs0), .cs1(nand_cs1), .ale(nand_ale), .cle(nand_cle),
        .se(nand_se), .wp(nand_wp), .pre(nand_pre), .we_n(nand_we_n),
        .re_n(nand_re_n), .oe(nand_oe)
    );

endmodule

// File: rtl/nand_bridge_checker.sv
module nand_bridge_checker #(
    parameter int REG_W  = 32,
    parameter int WR_LEN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             we_n,
    input logic             re_n,
    input logic             ale,
    input logic             cle,
    input logic             ready,
    input logic [REG_W-1:0] ctrl
);

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ready);

    a_r4_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl[0] && ctrl[20]) |-> (we_n && re_n && !ale && !cle));

    // R9: a hold phase follows every write strobe before release
    a_r9_hold_after: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> !ready);

    generate
        if (WR_LEN >= 2) begin : g_width
            a_r8_wr_width: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(we_n) |-> ($past(we_n, 2) == 1'b0));
        end
    endgenerate

endmodule

bind nand_pin_bridge nand_bridge_checker #(
    .REG_W(REG_W), .WR_LEN(WAIT_WR * CLK_MULT)
) i_chk (
    .clk(clk), .rst_n(rst_n), .we_n(nand_we_n), .re_n(nand_re_n),
    .ale(nand_ale), .cle(nand_cle), .ready(bus_ready), .ctrl(ctrl_q)
);

// File: tb/test_nand_pin_bridge.sv
module test_nand_pin_bridge;

    localparam int M   = 2;
    localparam int LAT = (1 + 2 + 1 + 1) * M + 1;
    localparam int NV  = 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_req = 0, bus_win = 0, bus_we = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        nand_cs0, nand_cs1, nand_ale, nand_cle, nand_se, nand_wp;
    logic        nand_pre, nand_we_n, nand_re_n, nand_oe;
    logic [7:0]  nand_dout;
    logic [7:0]  nand_din = '0;
    logic        nand_rb0 = 0, nand_rb1 = 0;

    always #5 clk = ~clk;

    nand_pin_bridge i_nand_pin_bridge (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_win(bus_win),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .nand_cs0(nand_cs0), .nand_cs1(nand_cs1), .nand_ale(nand_ale),
        .nand_cle(nand_cle), .nand_se(nand_se), .nand_wp(nand_wp),
        .nand_pre(nand_pre), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dout(nand_dout), .nand_oe(nand_oe), .nand_din(nand_din),
        .nand_rb0(nand_rb0), .nand_rb1(nand_rb1)
    );

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Pin monitor: captures levels during the strobe and counts phases
    bit         mon_on = 0;
    int         wcnt, rcnt, pcnt;
    logic       pre_act_lvl;
    logic [7:0] cap_pins;
    logic [7:0] cap_dout;
    always @(negedge clk) if (mon_on) begin
        if (!nand_we_n) wcnt++;
        if (!nand_re_n) rcnt++;
        if (nand_pre == pre_act_lvl) pcnt++;
        if ((!nand_we_n || !nand_re_n) && wcnt + rcnt == 1) begin
            cap_pins = {nand_oe, nand_cs0, nand_cs1, nand_ale, nand_cle,
                        nand_se, nand_wp, 1'b0};
            cap_dout = nand_dout;
        end
    end

    // R10: the device changes its output as soon as read-enable rises
    always @(posedge nand_re_n) nand_din <= ~nand_din;

    task automatic reg_wr(input [7:0] a, input [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_win = 0; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_req = 0;
    endtask

    task automatic reg_rd(input [7:0] a, output [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_win = 0; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_req = 0;
    endtask

    task automatic win(input [6:0] offs, input bit we, input [7:0] wd,
                       output [7:0] rd, output int lat);
        @(negedge clk);
        wcnt = 0; rcnt = 0; pcnt = 0; cap_pins = '0; cap_dout = '0;
        bus_req = 1; bus_win = 1; bus_we = we; bus_addr = {1'b0, offs};
        bus_wdata = {24'h0, wd}; mon_on = 1; lat = 0;
        #1;
        while (!bus_ready) begin
            @(negedge clk);
            lat++;
        end
        rd = bus_rdata[7:0];
        @(posedge clk); #1;
        bus_req = 0; mon_on = 0;
    endtask

    // {offset[6:0], we, wdata[7:0], device data[7:0]}
    localparam logic [23:0] VEC [NV] = '{
        {7'h18, 1'b1, 8'h70, 8'h00},
        {7'h14, 1'b1, 8'h2A, 8'h00},
        {7'h10, 1'b1, 8'hC3, 8'h00},
        {7'h10, 1'b0, 8'h00, 8'h5A},
        {7'h30, 1'b1, 8'h11, 8'h00},
        {7'h50, 1'b1, 8'h22, 8'h00},
        {7'h30, 1'b0, 8'h00, 8'hA5},
        {7'h08, 1'b1, 8'h90, 8'h00}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        logic [7:0]  rd;
        int          lat;
        logic [7:0]  e;

        pre_act_lvl = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        #1;
        chk(nand_we_n && nand_re_n && !nand_ale && !nand_cle && !nand_oe,
            "R1 strobes/latches idle",
            {nand_we_n, nand_re_n, nand_ale, nand_cle, nand_oe}, 5'b11000);
        chk({nand_cs0, nand_cs1, nand_se, nand_wp, nand_pre} == 5'b0,
            "R1 polarity lines low", {nand_cs0, nand_cs1, nand_se, nand_wp, nand_pre}, 0);
        reg_rd(8'hB0, r);
        chk(r == 0, "R1 ctrl reset", r, 0);
        reg_rd(8'hB4, r);
        chk(r[3] == 1, "R1 R7 done bit after reset", r, 32'h8);

        // R12 writable mask
        reg_wr(8'hB0, 32'hFFFF_FFFF);
        reg_rd(8'hB0, r);
        chk(r == 32'h0010_05F3, "R12 ctrl mask", r, 32'h0010_05F3);

        // R4 NAND mode on but chip enable off: no strobe, immediate ready
        reg_wr(8'hB0, 32'h0000_0001);
        nand_din = 8'h77;
        win(7'h18, 1'b1, 8'hFF, rd, lat);
        chk(lat == 0 && wcnt == 0, "R4 disabled write", lat, 0);
        win(7'h10, 1'b0, 8'h00, rd, lat);
        chk(lat == 0 && rcnt == 0 && rd == 0, "R4 disabled read", rd, 0);

        // Table walk: active-low polarities, CS follows address
        reg_wr(8'hB0, 32'h0010_00F3);
        pre_act_lvl = 0;
        for (int i = 0; i < NV; i++) begin
            logic [6:0] o;
            logic       w;
            logic [7:0] wd, dd;
            {o, w, wd, dd} = VEC[i];
            nand_din = dd;
            win(o, w, wd, rd, lat);
            // expected {oe, cs0, cs1, ale, cle, se, wp, 0}
            e = {w, ~o[4], 1'b1, o[2], o[3], ~o[5], ~o[6], 1'b0};
            chk(cap_pins == e, $sformatf("R2 R3 pins vec %0d", i), cap_pins, e);
            chk(lat == LAT, $sformatf("R9 latency vec %0d", i), lat, LAT);
            chk(pcnt == M, $sformatf("R5 precharge vec %0d", i), pcnt, M);
            if (w) begin
                chk(wcnt == 2 * M && rcnt == 0, $sformatf("R8 we width vec %0d", i), wcnt, 2 * M);
                chk(cap_dout == wd, $sformatf("R8 dout vec %0d", i), cap_dout, wd);
            end else begin
                chk(rcnt == 2 * M && wcnt == 0, $sformatf("R8 re width vec %0d", i), rcnt, 2 * M);
                chk(rd == dd, $sformatf("R10 read data vec %0d", i), rd, dd);
            end
        end
        reg_rd(8'hB4, r);
        chk(r[3] == 1, "R7 done after access", r[3], 1);

        // R5 active-high polarities
        reg_wr(8'hB0, 32'h0010_0003);
        pre_act_lvl = 1;
        win(7'h70, 1'b1, 8'h3C, rd, lat);
        e = {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
        chk(cap_pins == e, "R5 active-high lines", cap_pins, e);
        chk(pcnt == M, "R5 active-high precharge", pcnt, M);

        // R3 CS multiplexing off: CS asserted with offset bit 4 clear
        reg_wr(8'hB0, 32'h0010_00F1);
        pre_act_lvl = 0;
        win(7'h00, 1'b1, 8'h01, rd, lat);
        chk(cap_pins[6] == 0, "R3 cs held without mux", cap_pins[6], 0);

        // R6 routing to chip select 1 and ready/busy 1
        reg_wr(8'hB0, 32'h0010_05F3);
        win(7'h10, 1'b1, 8'h55, rd, lat);
        chk(cap_pins[6:5] == 2'b10, "R6 cs routed to cs1", cap_pins[6:5], 2'b10);
        nand_rb0 = 0; nand_rb1 = 1;
        reg_rd(8'hB4, r);
        chk(r[0] == 1, "R6 R7 rb1 selected high", r[0], 1);
        nand_rb1 = 0; nand_rb0 = 1;
        reg_rd(8'hB4, r);
        chk(r[0] == 0, "R6 R7 rb1 selected low", r[0], 0);
        reg_wr(8'hB0, 32'h0010_00F3);
        reg_rd(8'hB4, r);
        chk(r[0] == 1, "R7 rb0 mirrored", r[0], 1);

        // R11 strobes exclusive: captured via counters of the last read
        nand_din = 8'h3E;
        win(7'h10, 1'b0, 8'h00, rd, lat);
        chk(wcnt == 0 && rcnt == 2 * M, "R11 only read strobe", wcnt, 0);
        chk(rd == 8'h3E, "R10 sampled before re_n rise", rd, 8'h3E);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule